// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block recovers stereo PCM samples from a three-wire serial audio stream. A bit clock, a channel-select (word) clock and a data line arrive from an external source. The block runs entirely on the bit clock. Every incoming bit is sampled on the rising bit-clock edge. The receiver tracks word-clock transitions and assembles one word per half-frame.

A 3-bit format selector chooses one of three framings:
- an I2S-style framing, where the word is delayed by one bit;
- a start-aligned (left-justified) framing;
- an end-aligned (right-justified) framing, with a word length of 16, 18, 20 or 24 bits.

The selector is sampled at every word-clock transition, so a change never splits a word between two framings.

Once per stereo period the receiver presents a left/right pair as 24-bit two's-complement values, together with a single-cycle strobe. End-aligned words shorter than 24 bits are sign-extended. Start-aligned words are taken as the first 24 bits after their start point, so a shorter sender's word lands left-aligned. A downstream consumer only needs to latch both outputs when the strobe is high.

Top module: `sar_rx`

## Requirements
- R1: The format selector decodes as follows. 3'b000 is I2S-style. 3'b001, 3'b110 and 3'b111 are start-aligned. 3'b010 is end-aligned 24-bit, 3'b011 is end-aligned 20-bit, 3'b100 is end-aligned 16-bit and 3'b101 is end-aligned 18-bit.
- R2: Data is two's complement, sent MSB first, and sampled on the rising edge of the bit clock.
- R3: In I2S-style framing, the MSB is sampled on the second rising bit-clock edge after a word-clock transition and the next 23 bits follow it. A low word clock marks the left channel. All other bits of the half-frame are ignored.
- R4: In start-aligned framing, the MSB is sampled on the first rising bit-clock edge after a transition and 24 bits are taken. A high word clock marks the left channel. The bits from the 25th onward are ignored.
- R5: In end-aligned framing with word length N, the LSB is the last bit sampled before the next transition. The N-bit word is sign-extended from bit N-1 to 24 bits. A high word clock marks the left channel, and bits before the last N are ignored. With 32 bits per half-frame this ignores bits 0 to 31-N.
- R6: `pair_valid` is high for exactly one bit-clock cycle per stereo period. It rises in the cycle after the rising edge that first samples the transition ending the right half. It carries the left and right words of that period together.
- R7: `left_out` and `right_out` change only in a cycle where `pair_valid` is high.
- R8: The format selector is latched at each word-clock transition. A change made during a half-frame affects only the half-frames that begin after the next transition.
- R9: Reset clears both outputs and the strobe. A half-frame already under way when reset is released is discarded, so the first pair reported is the first one whose left half began at a transition seen after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Word clock selecting the channel of the current half-frame |
| sdin | input | 1 | Serial data, MSB first |
| fmt_sel | input | 3 | Framing and word-length selector (R1 encoding) |
| left_out | output | 24 | Last left-channel sample, sign-extended |
| right_out | output | 24 | Last right-channel sample, sign-extended |
| pair_valid | output | 1 | One-cycle strobe marking a new left/right pair |

## Verification
Every selector code is swept with the same twelve sample values:
- full-scale positive and negative;
- zero and minus one;
- two alternating patterns;
- pseudo-random words.

Those values are placed in the half-frame by the bench's own framing rules. All unused bit slots carry ones, so a receiver that reads one slot early or late, or lets padding into the word, gives a wrong value. The end-aligned widths tell the sign-extension boundaries apart, because the most negative value only matches when the extension starts at bit N-1. The aliased codes are run through the same sweep to show that they behave exactly like the start-aligned code. Separate runs cover:
- a selector change in the middle of a right half;
- a reset released in the middle of a half-frame, which shows that partial halves never reach the outputs.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int SW = 24;   // output sample width
  localparam int WW = 5;    // width of the word-length field

  typedef enum logic [1:0] {
    FR_I2S = 2'd0,
    FR_LJ  = 2'd1,
    FR_RJ  = 2'd2
  } frame_e;

  typedef struct packed {
    frame_e        kind;
    logic [WW-1:0] width;
  } fmt_t;

  // R1: selector code to framing and word length
  function automatic fmt_t decode_sel(input logic [2:0] code);
    fmt_t f;
    f.kind  = FR_LJ;
    f.width = WW'(SW);
    case (code)
      3'b000: f.kind = FR_I2S;
      3'b010: f.kind = FR_RJ;
      3'b011: begin f.kind = FR_RJ; f.width = 5'd20; end
      3'b100: begin f.kind = FR_RJ; f.width = 5'd16; end
      3'b101: begin f.kind = FR_RJ; f.width = 5'd18; end
      default: f.kind = FR_LJ;   // 001 and its aliases 110, 111
    endcase
    return f;
  endfunction

  // slot of the first data bit after a word-clock transition
  function automatic int lead_slot(input frame_e k);
    return (k == FR_I2S) ? 1 : 0;
  endfunction

  // sign-extend the low n bits of raw to the full sample width
  function automatic logic [SW-1:0] sext_low(input logic [SW-1:0] raw,
                                             input logic [WW-1:0] n);
    logic [SW-1:0] r;
    int top;
    top = int'(n) - 1;
    if (top < 0) top = 0;
    for (int i = 0; i < SW; i++) r[i] = (i <= top) ? raw[i] : raw[top];
    return r;
  endfunction

endpackage

// File: rtl/sar_lr_track.sv
module sar_lr_track #(
  parameter int CNT_W = 6
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             lrck,
  output logic             lr_edge,
  output logic             lr_prev,
  output logic [CNT_W-1:0] bit_idx
);
  localparam logic [CNT_W-1:0] IDX_MAX = '1;

  logic             lrck_q;
  logic             live_q;
  logic [CNT_W-1:0] cnt_q;

  // a transition only counts once a first level has been captured
  assign lr_edge = live_q && (lrck != lrck_q);
  assign lr_prev = lrck_q;

  always_comb begin
    if (lr_edge)               bit_idx = '0;
    else if (cnt_q == IDX_MAX) bit_idx = cnt_q;
    else                       bit_idx = cnt_q + 1'b1;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q <= 1'b0;
      live_q <= 1'b0;
      cnt_q  <= IDX_MAX;
    end else begin
      lrck_q <= lrck;
      live_q <= 1'b1;
      cnt_q  <= bit_idx;
    end
  end
endmodule

// File: rtl/sar_word_cap.sv
module sar_word_cap
  import sar_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             sdin,
  input  logic             lr_edge,
  input  logic [CNT_W-1:0] bit_idx,
  input  frame_e           cap_kind,
  input  fmt_t             done_fmt,
  output logic [SW-1:0]    word_done
);
  logic [SW-1:0] acc_q, acc_n;
  logic [SW-1:0] tail_q;
  int            pos;

  // start-aligned capture: bit slot relative to the first data slot
  always_comb begin
    pos   = int'(bit_idx) - lead_slot(cap_kind);
    acc_n = lr_edge ? '0 : acc_q;
    if (cap_kind != FR_RJ && pos >= 0 && pos < SW)
      acc_n[SW-1-pos] = sdin;
  end

  // the word of the half-frame that ends at this transition
  assign word_done = (done_fmt.kind == FR_RJ) ? sext_low(tail_q, done_fmt.width)
                                              : acc_q;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tail_q <= '0;
    end else begin
      acc_q  <= acc_n;
      tail_q <= {tail_q[SW-2:0], sdin};
    end
  end
endmodule

// File: rtl/sar_pair_out.sv
module sar_pair_out
  import sar_pkg::*;
(
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          lr_edge,
  input  logic          prev_is_left,
  input  logic [SW-1:0] word_done,
  output logic [SW-1:0] left_out,
  output logic [SW-1:0] right_out,
  output logic          pair_valid
);
  logic          primed_q;
  logic          left_ok_q;
  logic [SW-1:0] left_hold_q;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q    <= 1'b0;
      left_ok_q   <= 1'b0;
      left_hold_q <= '0;
      left_out    <= '0;
      right_out   <= '0;
      pair_valid  <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (lr_edge) begin
        primed_q <= 1'b1;
        if (primed_q) begin
          if (prev_is_left) begin
            left_hold_q <= word_done;
            left_ok_q   <= 1'b1;
          end else if (left_ok_q) begin
            left_out   <= left_hold_q;
            right_out  <= word_done;
            pair_valid <= 1'b1;
            left_ok_q  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_rx.sv
module sar_rx
  import sar_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          lrck,
  input  logic          sdin,
  input  logic [2:0]    fmt_sel,
  output logic [SW-1:0] left_out,
  output logic [SW-1:0] right_out,
  output logic          pair_valid
);
  logic             lr_edge;
  logic             lr_prev;
  logic [CNT_W-1:0] bit_idx;
  logic [2:0]       fmt_q;
  fmt_t             done_fmt;
  fmt_t             cap_fmt;
  logic             done_rj;
  logic             prev_is_left;
  logic [SW-1:0]    word_done;

  // selector is taken at each transition, for the half-frame it opens
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)       fmt_q <= 3'b000;
    else if (lr_edge) fmt_q <= fmt_sel;
  end

  assign done_fmt     = decode_sel(fmt_q);
  assign cap_fmt      = lr_edge ? decode_sel(fmt_sel) : done_fmt;
  assign done_rj      = (done_fmt.kind == FR_RJ);
  assign prev_is_left = (done_fmt.kind == FR_I2S) ? !lr_prev : lr_prev;

  sar_lr_track #(.CNT_W(CNT_W)) u_track (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .lrck    (lrck),
    .lr_edge (lr_edge),
    .lr_prev (lr_prev),
    .bit_idx (bit_idx)
  );

  sar_word_cap #(.CNT_W(CNT_W)) u_cap (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .sdin      (sdin),
    .lr_edge   (lr_edge),
    .bit_idx   (bit_idx),
    .cap_kind  (cap_fmt.kind),
    .done_fmt  (done_fmt),
    .word_done (word_done)
  );

  sar_pair_out u_pair (
    .sclk         (sclk),
    .rst_n        (rst_n),
    .lr_edge      (lr_edge),
    .prev_is_left (prev_is_left),
    .word_done    (word_done),
    .left_out     (left_out),
    .right_out    (right_out),
    .pair_valid   (pair_valid)
  );
endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk
  import sar_pkg::*;
(
  input logic          sclk,
  input logic          rst_n,
  input logic          lr_edge,
  input logic          pair_valid,
  input logic          done_rj,
  input logic [WW-1:0] done_width,
  input logic [SW-1:0] word_done,
  input logic [SW-1:0] left_out,
  input logic [SW-1:0] right_out
);
  function automatic logic ext_ok(input logic [SW-1:0] w, input logic [WW-1:0] n);
    int top;
    top = int'(n) - 1;
    if (top < 0) return 1'b0;
    for (int i = 0; i < SW; i++)
      if (i > top && w[i] != w[top]) return 1'b0;
    return 1'b1;
  endfunction

  assert_strobe_on_edge_R6: assert property (@(posedge sclk) disable iff (!rst_n)
    pair_valid |-> $past(lr_edge));

  assert_strobe_single_R6: assert property (@(posedge sclk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  assert_left_hold_R7: assert property (@(posedge sclk) disable iff (!rst_n)
    (left_out != $past(left_out)) |-> pair_valid);

  assert_right_hold_R7: assert property (@(posedge sclk) disable iff (!rst_n)
    (right_out != $past(right_out)) |-> pair_valid);

  assert_rj_sign_R5: assert property (@(posedge sclk) disable iff (!rst_n)
    (lr_edge && done_rj) |-> ext_ok(word_done, done_width));
endmodule

bind sar_rx sar_rx_chk u_chk (
  .sclk       (sclk),
  .rst_n      (rst_n),
  .lr_edge    (lr_edge),
  .pair_valid (pair_valid),
  .done_rj    (done_rj),
  .done_width (done_fmt.width),
  .word_done  (word_done),
  .left_out   (left_out),
  .right_out  (right_out)
);

// File: tb/tb_sar_rx.sv
`timescale 1ns/1ps
module tb_sar_rx;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrck = 1'b0;
  logic        sdin = 1'b0;
  logic [2:0]  dif = 3'b000;
  logic [23:0] left_out, right_out;
  logic        pair_valid;

  int n_chk = 0;
  int n_fail = 0;
  int n_exp = 0;
  int n_got = 0;
  int hold_bad = 0;
  logic [23:0] exp_l [0:127];
  logic [23:0] exp_r [0:127];
  string       exp_t [0:127];
  logic [23:0] prev_l = '0, prev_r = '0;
  logic        rst_seen = 1'b0;

  always #5 sclk = ~sclk;

  sar_rx dut (
    .sclk(sclk), .rst_n(rst_n), .lrck(lrck), .sdin(sdin), .fmt_sel(dif),
    .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench view of the selector encoding (R1)
  function automatic bit is_rj(input logic [2:0] c);
    return (c == 3'b010 || c == 3'b011 || c == 3'b100 || c == 3'b101);
  endfunction
  function automatic int wbits(input logic [2:0] c);
    case (c)
      3'b011:  return 20;
      3'b100:  return 16;
      3'b101:  return 18;
      default: return 24;
    endcase
  endfunction
  function automatic logic [23:0] shape(input logic [2:0] c, input logic [23:0] p);
    return is_rj(c) ? (p >> (24 - wbits(c))) : p;
  endfunction
  function automatic logic [23:0] expect_of(input logic [2:0] c, input logic [23:0] v);
    logic signed [23:0] t;
    if (!is_rj(c)) return v;
    t = $signed(v << (24 - wbits(c)));
    return t >>> (24 - wbits(c));
  endfunction
  function automatic logic [23:0] pat(input int i);
    case (i)
      0: return 24'h7FFFFF;
      1: return 24'h800000;
      2: return 24'h000000;
      3: return 24'hFFFFFF;
      4: return 24'h5A5A5A;
      5: return 24'hA5A5A5;
      default: return 24'((i * 32'h9E3779) ^ 32'h0C3A51);
    endcase
  endfunction

  // one half-frame of 32 bit slots; unused slots carry ones
  task automatic send_half(input logic lvl, input logic [2:0] c, input logic [23:0] v,
                           input int chg_bit, input logic [2:0] newc);
    int w;
    logic b;
    w = wbits(c);
    for (int idx = 0; idx < 32; idx++) begin
      if (c == 3'b000)  b = (idx >= 1 && idx <= 24) ? v[24-idx] : 1'b1;
      else if (is_rj(c)) b = (idx >= 32 - w) ? v[31-idx] : 1'b1;
      else               b = (idx <= 23) ? v[23-idx] : 1'b1;
      @(negedge sclk);
      lrck = lvl;
      sdin = b;
      if (idx == chg_bit) dif = newc;
    end
  endtask

  task automatic send_frame(input logic [2:0] c, input logic [23:0] pl, input logic [23:0] pr,
                            input string tag, input int chg_bit, input logic [2:0] newc);
    logic lv;
    logic [23:0] vl, vr;
    lv = (c == 3'b000) ? 1'b0 : 1'b1;
    vl = shape(c, pl);
    vr = shape(c, pr);
    exp_l[n_exp] = expect_of(c, vl);
    exp_r[n_exp] = expect_of(c, vr);
    exp_t[n_exp] = tag;
    n_exp++;
    send_half(lv, c, vl, 99, c);
    send_half(!lv, c, vr, chg_bit, newc);
  endtask

  task automatic do_reset(input logic [2:0] c, input logic lvl);
    @(posedge sclk); #2;
    rst_n = 1'b0;
    dif = c;
    lrck = lvl;
    sdin = 1'b0;
    repeat (3) @(posedge sclk);
    #2 rst_n = 1'b1;
  endtask

  // R6: strobe in the cycle after the closing transition, one cycle long
  task automatic finish_run(input logic lv_left);
    @(negedge sclk);
    lrck = lv_left;
    sdin = 1'b0;
    @(negedge sclk);
    check(pair_valid == 1'b1, "R6", "strobe after closing transition", 24'(pair_valid), 24'd1);
    @(negedge sclk);
    check(pair_valid == 1'b0, "R6", "strobe width", 24'(pair_valid), 24'd0);
    @(negedge sclk); #1;
    check(n_got == n_exp, "R6", "pairs reported", 24'(n_got), 24'(n_exp));
  endtask

  task automatic run_code(input logic [2:0] c, input string tag);
    logic lv;
    lv = (c == 3'b000) ? 1'b0 : 1'b1;
    do_reset(c, !lv);
    send_half(!lv, c, 24'h000000, 99, c);  // warm-up half at right level
    for (int k = 0; k < 6; k++) send_frame(c, pat(2*k), pat(2*k+1), tag, 99, c);
    finish_run(lv);
  endtask

  // monitor: compare every strobe with the next expected pair
  always @(negedge sclk) begin
    if (rst_n && rst_seen) begin
      if (pair_valid) begin
        if (n_got < n_exp) begin
          check(left_out == exp_l[n_got], exp_t[n_got], "left", left_out, exp_l[n_got]);
          check(right_out == exp_r[n_got], exp_t[n_got], "right", right_out, exp_r[n_got]);
        end else begin
          check(1'b0, "R9", "unexpected strobe", left_out, 24'd0);
        end
        n_got++;
      end else if (left_out != prev_l || right_out != prev_r) begin
        hold_bad++;
      end
    end
    prev_l = left_out;
    prev_r = right_out;
    rst_seen = rst_n;
  end

  initial begin
    repeat (150000) @(posedge sclk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R9: reset state
    do_reset(3'b000, 1'b1);
    @(negedge sclk);
    check(pair_valid == 1'b0, "R9", "strobe at reset", 24'(pair_valid), 24'd0);
    check(left_out == 24'd0, "R9", "left at reset", left_out, 24'd0);
    check(right_out == 24'd0, "R9", "right at reset", right_out, 24'd0);

    // R1 sweep of every selector code, R2 value patterns
    run_code(3'b000, "R3 R2");
    run_code(3'b001, "R4 R2");
    run_code(3'b010, "R5 R2 24b");
    run_code(3'b011, "R5 20b");
    run_code(3'b100, "R5 16b");
    run_code(3'b101, "R5 18b");
    run_code(3'b110, "R1 alias 110");
    run_code(3'b111, "R1 alias 111");

    // R9: a half under way at reset release is discarded
    do_reset(3'b001, 1'b1);
    send_half(1'b1, 3'b001, 24'h123456, 99, 3'b001);
    send_half(1'b0, 3'b001, 24'h654321, 99, 3'b001);
    send_frame(3'b001, 24'h0F0F0F, 24'hF0F0F0, "R9", 99, 3'b001);
    send_frame(3'b001, 24'h13579B, 24'hECA864, "R9", 99, 3'b001);
    finish_run(1'b1);

    // R8: selector change mid right half applies from the next transition
    do_reset(3'b001, 1'b0);
    send_half(1'b0, 3'b001, 24'h000000, 99, 3'b001);
    send_frame(3'b001, 24'h3C3C3C, 24'hC3C3C3, "R8", 99, 3'b001);
    send_frame(3'b001, 24'h112233, 24'h998877, "R8", 5, 3'b100);
    send_frame(3'b100, 24'h800000, 24'h7FFFFF, "R8", 99, 3'b100);
    send_frame(3'b100, 24'hFEDCBA, 24'h0ABCDE, "R8", 99, 3'b100);
    finish_run(1'b1);

    check(hold_bad == 0, "R7", "output change without strobe", 24'(hold_bad), 24'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule